// File: doc/BRIEF.md
# Four-Channel DAC Sample Scheduler

This block paces a four-output digital-to-analogue converter at a fixed sample rate. A free-running divider on the 50 MHz system clock produces one sample tick every 6250 cycles (8 kHz). On each tick that finds the block idle, it computes one new 12-bit code per channel and hands four requests, one per channel, to a downstream serial command-word transmitter over a valid/ready handshake. Each request carries a 4-bit command, a 4-bit channel address and the 12-bit code. Because every channel is written with the update-immediately command, the analogue outputs change one after the other rather than together.

Channels A and C both carry a 2 kHz square wave that alternates between two fixed codes. Channel B carries a triangle wave that climbs and falls in steps of 204. Channel D takes the code presented on an external sine input, captured at the tick. A 16-bit sample counter advances with every accepted tick, and its upper byte drives eight LEDs as a heartbeat. If the transmitter is still busy with the previous sample when the next tick arrives, that tick is dropped and a sticky overrun flag is raised.

The sequencer is a five-state machine. ST_IDLE waits for a tick; a tick in ST_IDLE moves to ST_CH_A (transition "start"). ST_CH_A, ST_CH_B, ST_CH_C and ST_CH_D each present one request and stay until the transmitter accepts it; acceptance moves A to B, B to C, C to D ("advance"), and D back to ST_IDLE ("finish"). A tick seen in any state other than ST_IDLE takes the "drop" path: no state change, overrun set.

Top module: `dac_sample_sched`

## Requirements
- R1: The sample tick occurs once every TICK_DIV clock cycles (6250 by default); the internal divider counts 0 to TICK_DIV-1 and wraps to 0.
- R2: For each accepted tick four requests are issued in the order A, B, C, D with tx_addr 4'b0000, 4'b0001, 4'b0010, 4'b0011; each request holds tx_valid, tx_addr and tx_data steady until the cycle tx_ready is high, and tx_valid is low after D is accepted.
- R3: Every request carries tx_cmd = 4'b0011 (write and update immediately).
- R4: Channels A and C carry the same square code: after reset the first two samples are 12'hCCD, the next two 12'h333, repeating every four samples.
- R5: Channel B starts at 0 after reset; the first sample is 204, each sample adds 204 until 4080, then subtracts 204 until 0, then climbs again (period 40 samples).
- R6: The channel D code equals sine_code as sampled in the tick cycle of that sample, regardless of later changes of sine_code.
- R7: A 16-bit sample counter increments once per accepted tick; led shows its bits 15:8.
- R8: A tick arriving while any request is still pending is dropped: waveform phases and the sample counter do not advance, the pending request stays unchanged, and overrun goes high and stays high until reset.
- R9: Reset clears the divider, waveform phases, all channel codes and the sample counter; during and just after reset tx_valid, tx_cmd, tx_addr, tx_data, led and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_ready | input | 1 | Transmitter can accept a request this cycle |
| sine_code | input | 12 | External sine code for channel D |
| tx_valid | output | 1 | A request is presented |
| tx_cmd | output | 4 | Command field of the request |
| tx_addr | output | 4 | Channel address of the request |
| tx_data | output | 12 | 12-bit code of the request |
| led | output | 8 | Upper byte of the sample counter |
| overrun | output | 1 | Sticky flag: a tick was dropped |

## Verification
The assertions assume the transmitter behaves as a plain valid/ready sink: tx_ready may be low for any number of cycles, and a request counts as taken only in a cycle where both tx_valid and tx_ready are high. They also assume the step and top parameters make the triangle land exactly on its turning points. The stimulus runs a reduced divider of 40 cycles with tx_ready held high for 260 consecutive samples, long enough to sweep several triangle and square periods and carry the counter into the LED byte. It then holds tx_ready low across two ticks to force drops, and ends with a mid-run reset, keeping every input change on the falling edge.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CH_A,
        ST_CH_B,
        ST_CH_C,
        ST_CH_D
    } seq_state_t;

    localparam logic [3:0] CMD_WR_UPD = 4'b0011;

    localparam logic [3:0] ADDR_CH_A = 4'b0000;
    localparam logic [3:0] ADDR_CH_B = 4'b0001;
    localparam logic [3:0] ADDR_CH_C = 4'b0010;
    localparam logic [3:0] ADDR_CH_D = 4'b0011;

endpackage

// File: rtl/dss_tick_gen.sv
module dss_tick_gen #(
    parameter int TICK_DIV = 6250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R1: after a tick the divider restarts from zero
    p_tick_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

    // R1: the divider never leaves its range
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R1: without a tick the divider moves up by exactly one
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/dss_square_gen.sv
module dss_square_gen #(
    parameter int CODE_W = 12,
    parameter int HI     = 'hCCD,
    parameter int LO     = 'h333,
    parameter int HALF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [CODE_W-1:0] code
);
    localparam int PERIOD = 2 * HALF;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0]   PH_HALF = PH_W'(HALF);
    localparam logic [CODE_W-1:0] HI_C    = CODE_W'(HI);
    localparam logic [CODE_W-1:0] LO_C    = CODE_W'(LO);

    logic [PH_W-1:0]   phase_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            code_q  <= '0;
        end else if (adv) begin
            code_q  <= (phase_q < PH_HALF) ? HI_C : LO_C;
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign code = code_q;

    // R4: only the two levels (or the reset zero) ever appear
    p_sq_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == HI_C) || (code_q == LO_C) || (code_q == '0));

    // R8: no advance, no change of the square code
    p_sq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(code_q) && $stable(phase_q));

endmodule

// File: rtl/dss_tri_gen.sv
module dss_tri_gen #(
    parameter int CODE_W = 12,
    parameter int STEP   = 204,
    parameter int TOP    = 4080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);
    localparam logic [CODE_W-1:0] TOP_C  = CODE_W'(TOP);

    logic [CODE_W-1:0] code_q;
    logic              up_q;
    logic [CODE_W-1:0] nxt_up;
    logic [CODE_W-1:0] nxt_dn;

    assign nxt_up = code_q + STEP_C;
    assign nxt_dn = code_q - STEP_C;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            up_q   <= 1'b1;
        end else if (adv) begin
            if (up_q) begin
                code_q <= nxt_up;
                if (nxt_up == TOP_C) begin
                    up_q <= 1'b0;
                end
            end else begin
                code_q <= nxt_dn;
                if (nxt_dn == '0) begin
                    up_q <= 1'b1;
                end
            end
        end
    end

    assign code = code_q;

    // R5: the triangle stays inside its range
    p_tri_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= TOP_C);

    // R5: each advance moves the code by exactly one step
    p_tri_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (code_q == $past(code_q) + STEP_C) || (code_q == $past(code_q) - STEP_C));

    // R8: the triangle holds when no sample is accepted
    p_tri_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(code_q) && $stable(up_q));

endmodule

// File: rtl/dss_seq_fsm.sv
module dss_seq_fsm
    import dss_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int SCNT_W = 16,
    parameter int LED_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_ready,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic [CODE_W-1:0] code_c,
    input  logic [CODE_W-1:0] sine_code,
    output logic              adv,
    output logic              tx_valid,
    output logic [3:0]        tx_cmd,
    output logic [3:0]        tx_addr,
    output logic [CODE_W-1:0] tx_data,
    output logic [LED_W-1:0]  led,
    output logic              overrun
);
    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [SCNT_W-1:0] sample_q;
    logic [CODE_W-1:0] code_d_q;
    logic              overrun_q;

    assign adv = tick && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick)     state_d = ST_CH_A;
            ST_CH_A: if (tx_ready) state_d = ST_CH_B;
            ST_CH_B: if (tx_ready) state_d = ST_CH_C;
            ST_CH_C: if (tx_ready) state_d = ST_CH_D;
            ST_CH_D: if (tx_ready) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // sample-side registers: counter, channel D capture, overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q  <= '0;
            code_d_q  <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (adv) begin
                sample_q <= sample_q + 1'b1;
                code_d_q <= sine_code;
            end
            if (tick && (state_q != ST_IDLE)) begin
                overrun_q <= 1'b1;
            end
        end
    end

    // request outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_cmd   = '0;
        tx_addr  = '0;
        tx_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CH_A: begin
                tx_valid = 1'b1;
                tx_cmd   = CMD_WR_UPD;
                tx_addr  = ADDR_CH_A;
                tx_data  = code_a;
            end
            ST_CH_B: begin
                tx_valid = 1'b1;
                tx_cmd   = CMD_WR_UPD;
                tx_addr  = ADDR_CH_B;
                tx_data  = code_b;
            end
            ST_CH_C: begin
                tx_valid = 1'b1;
                tx_cmd   = CMD_WR_UPD;
                tx_addr  = ADDR_CH_C;
                tx_data  = code_c;
            end
            ST_CH_D: begin
                tx_valid = 1'b1;
                tx_cmd   = CMD_WR_UPD;
                tx_addr  = ADDR_CH_D;
                tx_data  = code_d_q;
            end
        endcase
    end

    assign led     = sample_q[SCNT_W-1 -: LED_W];
    assign overrun = overrun_q;

    // R2: a stalled request keeps its address and data
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_addr) && $stable(tx_data));

    // R2: accepting A leads to B, accepting D returns to idle
    p_order_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CH_A && tx_ready) |=> (state_q == ST_CH_B));
    p_order_d_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CH_D && tx_ready) |=> !tx_valid);

    // R7: counter advances by one per accepted tick and holds otherwise
    p_cnt_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (sample_q == $past(sample_q) + 1'b1));
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sample_q));

    // R8: a dropped tick raises the flag, and the flag never falls
    p_drop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tx_valid) |=> overrun);
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6: channel D code only changes on an accepted tick
    p_d_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(code_d_q));

endmodule

// File: rtl/dac_sample_sched.sv
module dac_sample_sched #(
    parameter int TICK_DIV = 6250,
    parameter int CODE_W   = 12,
    parameter int SQ_HI    = 'hCCD,
    parameter int SQ_LO    = 'h333,
    parameter int SQ_HALF  = 2,
    parameter int TRI_STEP = 204,
    parameter int TRI_TOP  = 4080,
    parameter int SCNT_W   = 16,
    parameter int LED_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_ready,
    input  logic [CODE_W-1:0] sine_code,
    output logic              tx_valid,
    output logic [3:0]        tx_cmd,
    output logic [3:0]        tx_addr,
    output logic [CODE_W-1:0] tx_data,
    output logic [LED_W-1:0]  led,
    output logic              overrun
);
    logic              tick;
    logic              adv;
    logic [CODE_W-1:0] sq_code;
    logic [CODE_W-1:0] tri_code;

    dss_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dss_square_gen #(
        .CODE_W (CODE_W),
        .HI     (SQ_HI),
        .LO     (SQ_LO),
        .HALF   (SQ_HALF)
    ) u_square (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .code  (sq_code)
    );

    dss_tri_gen #(
        .CODE_W (CODE_W),
        .STEP   (TRI_STEP),
        .TOP    (TRI_TOP)
    ) u_tri (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .code  (tri_code)
    );

    dss_seq_fsm #(
        .CODE_W (CODE_W),
        .SCNT_W (SCNT_W),
        .LED_W  (LED_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_ready  (tx_ready),
        .code_a    (sq_code),
        .code_b    (tri_code),
        .code_c    (sq_code),
        .sine_code (sine_code),
        .adv       (adv),
        .tx_valid  (tx_valid),
        .tx_cmd    (tx_cmd),
        .tx_addr   (tx_addr),
        .tx_data   (tx_data),
        .led       (led),
        .overrun   (overrun)
    );

    // R3: every presented request uses the immediate-update command
    p_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_cmd == 4'b0011));

    // R2: requests only ever target the four channel addresses
    p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_addr <= 4'b0011));

endmodule

// File: tb/tb_dac_sample_sched.sv
module tb_dac_sample_sched;

    localparam int DIV = 40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_ready;
    logic [11:0] sine_code;
    logic        tx_valid;
    logic [3:0]  tx_cmd;
    logic [3:0]  tx_addr;
    logic [11:0] tx_data;
    logic [7:0]  led;
    logic        overrun;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_sample_sched #(.TICK_DIV(DIV)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_ready  (tx_ready),
        .sine_code (sine_code),
        .tx_valid  (tx_valid),
        .tx_cmd    (tx_cmd),
        .tx_addr   (tx_addr),
        .tx_data   (tx_data),
        .led       (led),
        .overrun   (overrun)
    );

    function automatic int exp_sq(input int n);
        return (((n - 1) % 4) < 2) ? 'hCCD : 'h333;
    endfunction

    function automatic int exp_tri(input int n);
        int k;
        k = n % 40;
        return (k <= 20) ? k * 204 : (40 - k) * 204;
    endfunction

    function automatic int exp_sine(input int n);
        return (n * 37 + 5) % 4096;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_req();
        int waited;
        waited = 0;
        while (!tx_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        if (!tx_valid) chk(1'b0, "R1 tick never came", 0, 1);
    endtask

    // walks the four requests of sample n, tx_ready assumed high
    task automatic check_sample(input int n);
        for (int ch = 0; ch < 4; ch++) begin
            chk(tx_valid == 1'b1, "R2 valid", int'(tx_valid), 1);
            chk(tx_addr == 4'(ch), "R2 order/addr", int'(tx_addr), ch);
            chk(tx_cmd == 4'b0011, "R3 cmd", int'(tx_cmd), 3);
            case (ch)
                0: chk(int'(tx_data) == exp_sq(n),  "R4 chan A", int'(tx_data), exp_sq(n));
                1: chk(int'(tx_data) == exp_tri(n), "R5 chan B", int'(tx_data), exp_tri(n));
                2: chk(int'(tx_data) == exp_sq(n),  "R4 chan C", int'(tx_data), exp_sq(n));
                default: chk(int'(tx_data) == exp_sine(n), "R6 chan D", int'(tx_data), exp_sine(n));
            endcase
            if (ch == 0) chk(int'(led) == ((n >> 8) & 255), "R7 led", int'(led), (n >> 8) & 255);
            if (ch == 3) sine_code = 12'(exp_sine(n + 1));
            @(negedge clk);
        end
        chk(tx_valid == 1'b0, "R2 idle after D", int'(tx_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int last_start;
        bit held_ok;
        rst_n     = 1'b0;
        tx_ready  = 1'b1;
        sine_code = 12'(exp_sine(1));
        repeat (5) @(negedge clk);

        // R9: reset state at the ports
        chk(tx_valid == 1'b0, "R9 valid", int'(tx_valid), 0);
        chk(tx_data == 12'd0 && tx_cmd == 4'd0 && tx_addr == 4'd0, "R9 request fields", int'(tx_data), 0);
        chk(led == 8'd0, "R9 led", int'(led), 0);
        chk(overrun == 1'b0, "R9 overrun", int'(overrun), 0);
        rst_n = 1'b1;

        // sweep: R1 period, R2..R7 content over 260 samples
        last_start = -1;
        for (int n = 1; n <= 260; n++) begin
            wait_req();
            if (last_start >= 0) chk(cyc - last_start == DIV, "R1 tick period", cyc - last_start, DIV);
            last_start = cyc;
            check_sample(n);
        end
        chk(overrun == 1'b0, "R8 no overrun with ready high", int'(overrun), 0);

        // R8: stall the transmitter across two ticks
        tx_ready = 1'b0;
        wait_req();
        held_ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (!tx_valid || tx_addr != 4'd0 || int'(tx_data) != exp_sq(261)) held_ok = 1'b0;
            @(negedge clk);
        end
        chk(held_ok, "R8 pending request unchanged", int'(held_ok), 1);
        chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        tx_ready = 1'b1;
        check_sample(261);
        wait_req();
        chk(tx_addr == 4'd0 && int'(tx_data) == exp_sq(262), "R8 square not advanced by drops", int'(tx_data), exp_sq(262));
        check_sample(262);
        chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);

        // R9: mid-run reset restarts phases and clears state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(overrun == 1'b0, "R9 overrun cleared", int'(overrun), 0);
        chk(led == 8'd0 && tx_valid == 1'b0, "R9 led and valid cleared", int'(led), 0);
        sine_code = 12'(exp_sine(1));
        rst_n = 1'b1;
        wait_req();
        check_sample(1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule